// File: doc/BRIEF.md
# Hamming Distance Class Judge

This block turns the set of pairwise decisions for one pixel into a class label. In a one-against-one multi-class scheme each binary classifier settles one pair of classes. Their decision bits arrive together as one vector. The judge keeps an identifying code for every class, and each code position is either a value the class expects or a don't-care. For every class it counts the positions where the decision vector disagrees with the cared-for code bits. It then reports the class with the smallest count, together with that count.

Codes are loaded through a write port that takes a class index, a value word and a care word. Decision vectors enter on a valid/ready handshake. The datapath is two register stages deep: a popcount stage, then a minimum-search stage. It accepts one vector per cycle and reports each result on a valid output after a fixed delay. There is no output backpressure.

Top module: `hamming_class_judge`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every class code has all care bits at 0, so every class distance is 0.
- R2: The distance for class c is popcount((in_bits XOR value_c) AND care_c). `out_dist` reports the smallest distance over all classes, which lies between 0 and NUM_CLASSES*(NUM_CLASSES-1)/2 inclusive.
- R3: A code position whose care bit is 0 adds nothing to that class's distance, whatever the decision bit or the stored value bit is.
- R4: `out_label` is the index of the class with the smallest distance. Index 0 is the first class and index NUM_CLASSES-1 is the last.
- R5: When several classes share the smallest distance, the lowest index wins.
- R6: A vector accepted at a clock edge (`in_valid` and `in_ready` both high) gives `out_valid` high for exactly one cycle, starting right after the next clock edge. The result therefore appears two edges after the input was presented.
- R7: Vectors presented on consecutive cycles produce results on consecutive cycles, in the same order, with no gaps.
- R8: While `cfg_we` is high, `in_ready` is 0 and a presented vector is not accepted, so it produces no result. A code written at an edge applies to every vector accepted at later edges. A write whose `cfg_idx` is NUM_CLASSES or more is ignored.
- R9: Bit k of `in_bits` holds the decision for the k-th class pair. Pairs are ordered (0,1), (0,2), ..., (0,N-1), (1,2), ..., (N-2,N-1). `cfg_value` and `cfg_care` use the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decision vector present |
| in_ready | output | 1 | Vector accepted at the next edge when high |
| in_bits | input | VEC_W (120) | Pairwise decision bits |
| cfg_we | input | 1 | Code write strobe |
| cfg_idx | input | IDX_W (4) | Class index to write |
| cfg_value | input | VEC_W (120) | Expected bit value per position |
| cfg_care | input | VEC_W (120) | 1 = position counts, 0 = don't-care |
| out_valid | output | 1 | Result present for one cycle |
| out_label | output | IDX_W (4) | Winning class index |
| out_dist | output | DIST_W (7) | Winning class distance |

## Verification
The assertions check on every cycle that the two-edge gap between acceptance and `out_valid` holds. They also check that a cycle with a code write never yields a result two edges later, and that the reported label and distance stay in their legal ranges. Whether the label is truly the minimum-distance class needs a model of the codes, so only the bench's scenarios can show it. The same holds for don't-care positions being ignored, for ties resolving to the lowest index, for results keeping their order in a back-to-back stream, and for a new code applying to the very next vector.

// File: rtl/hamming_class_judge.sv
module hamming_class_judge #(
  parameter  int NUM_CLASSES = 16,
  localparam int VEC_W  = NUM_CLASSES * (NUM_CLASSES - 1) / 2,
  localparam int DIST_W = $clog2(VEC_W + 1),
  localparam int IDX_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_bits,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [VEC_W-1:0]  cfg_value,
  input  logic [VEC_W-1:0]  cfg_care,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_label,
  output logic [DIST_W-1:0] out_dist
);

  function automatic logic [DIST_W-1:0] popcnt(input logic [VEC_W-1:0] v);
    logic [DIST_W-1:0] n;
    n = '0;
    for (int i = 0; i < VEC_W; i++) n = n + DIST_W'(v[i]);
    return n;
  endfunction

  logic [VEC_W-1:0]  code_val  [NUM_CLASSES];
  logic [VEC_W-1:0]  code_care [NUM_CLASSES];
  logic [DIST_W-1:0] dist_now  [NUM_CLASSES];
  logic [DIST_W-1:0] s1_dist   [NUM_CLASSES];
  logic              s1_valid;
  logic [IDX_W-1:0]  best_idx;
  logic [DIST_W-1:0] best_dist;

  wire accept = in_valid && in_ready;
  assign in_ready = !cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        code_val[c]  <= '0;
        code_care[c] <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < NUM_CLASSES)) begin
      code_val[cfg_idx]  <= cfg_value;
      code_care[cfg_idx] <= cfg_care;
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_dist
    assign dist_now[c] = popcnt((in_bits ^ code_val[c]) & code_care[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      for (int c = 0; c < NUM_CLASSES; c++) s1_dist[c] <= '0;
    end else begin
      s1_valid <= accept;
      if (accept)
        for (int c = 0; c < NUM_CLASSES; c++) s1_dist[c] <= dist_now[c];
    end
  end

  always_comb begin
    best_idx  = '0;
    best_dist = s1_dist[0];
    for (int c = 1; c < NUM_CLASSES; c++) begin
      if (s1_dist[c] < best_dist) begin
        best_dist = s1_dist[c];
        best_idx  = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_label <= '0;
      out_dist  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_label <= best_idx;
        out_dist  <= best_dist;
      end
    end
  end

endmodule

// File: rtl/hamming_class_judge_chk.sv
module hamming_class_judge_chk #(
  parameter  int NUM_CLASSES = 16,
  localparam int VEC_W  = NUM_CLASSES * (NUM_CLASSES - 1) / 2,
  localparam int DIST_W = $clog2(VEC_W + 1),
  localparam int IDX_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_we,
  input logic              out_valid,
  input logic [IDX_W-1:0]  out_label,
  input logic [DIST_W-1:0] out_dist
);

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_ready, 2)); // R6

  AST_CFG_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ##1 !out_valid); // R8

  AST_DIST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_dist) <= VEC_W); // R2

  AST_LABEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_label) < NUM_CLASSES); // R4

endmodule

bind hamming_class_judge hamming_class_judge_chk #(.NUM_CLASSES(NUM_CLASSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_we(cfg_we), .out_valid(out_valid), .out_label(out_label), .out_dist(out_dist)
);

// File: tb/sim_hamming_class_judge.sv
`timescale 1ns/1ps
module sim_hamming_class_judge;
  localparam int K      = 16;
  localparam int VEC_W  = K * (K - 1) / 2;
  localparam int DIST_W = $clog2(VEC_W + 1);
  localparam int IDX_W  = $clog2(K);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, cfg_we = 0;
  logic in_ready, out_valid;
  logic [VEC_W-1:0] in_bits = '0, cfg_value = '0, cfg_care = '0;
  logic [IDX_W-1:0] cfg_idx = '0, out_label;
  logic [DIST_W-1:0] out_dist;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [VEC_W-1:0] mv [K];
  logic [VEC_W-1:0] mc [K];

  always #2 clk = ~clk;

  hamming_class_judge #(.NUM_CLASSES(K)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_value(cfg_value), .cfg_care(cfg_care),
    .out_valid(out_valid), .out_label(out_label), .out_dist(out_dist));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pair_pos(input int a, input int b);
    int p = 0;
    for (int i = 0; i < K; i++)
      for (int j = i + 1; j < K; j++) begin
        if (i == a && j == b) return p;
        p++;
      end
    return -1;
  endfunction

  task automatic model(input logic [VEC_W-1:0] v, output int lbl, output int dst);
    lbl = 0; dst = VEC_W + 1;
    for (int c = 0; c < K; c++) begin
      int d = $countones((v ^ mv[c]) & mc[c]);
      if (d < dst) begin dst = d; lbl = c; end
    end
  endtask

  task automatic write_code(input int idx, input logic [VEC_W-1:0] val, input logic [VEC_W-1:0] care);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_value = val; cfg_care = care;
    @(negedge clk);
    cfg_we = 0;
    if (idx < K) begin mv[idx] = val; mc[idx] = care; end
  endtask

  task automatic natural_code(input int c, output logic [VEC_W-1:0] val, output logic [VEC_W-1:0] care);
    val = '0; care = '0;
    for (int j = 0; j < K; j++) begin
      if (j > c) begin val[pair_pos(c, j)] = 1'b1; care[pair_pos(c, j)] = 1'b1; end
      if (j < c) begin val[pair_pos(j, c)] = 1'b0; care[pair_pos(j, c)] = 1'b1; end
    end
  endtask

  function automatic logic [VEC_W-1:0] vote_for(input int w);
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W; k++) v[k] = 1'($urandom);
    for (int j = 0; j < K; j++) begin
      if (j > w) v[pair_pos(w, j)] = 1'b1;
      if (j < w) v[pair_pos(j, w)] = 1'b0;
    end
    return v;
  endfunction

  task automatic run_one(input logic [VEC_W-1:0] v, input string tag);
    int el, ed;
    model(v, el, ed);
    @(negedge clk);
    in_valid = 1; in_bits = v;
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1'b0, {tag, " early valid"}, out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    check(int'(out_label) == el, {tag, " label"}, out_label, el);
    check(int'(out_dist) == ed, {tag, " dist"}, out_dist, ed);
    @(negedge clk);
    check(out_valid == 1'b0, {tag, " single pulse R6"}, out_valid, 0);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    run_one({VEC_W{1'b1}}, "R1 R5 all-zero care");
  endtask

  task automatic t_load_natural;
    logic [VEC_W-1:0] v, c;
    for (int k = 0; k < K; k++) begin
      natural_code(k, v, c);
      write_code(k, v, c);
    end
  endtask

  task automatic t_winners;
    int list [5] = '{0, 3, 7, 12, 15};
    foreach (list[i]) begin
      logic [VEC_W-1:0] v = vote_for(list[i]);
      run_one(v, "R2 R4 R9 consistent vote");
      check(int'(out_label) == list[i] && out_dist == 0, "R4 R9 winner", out_label, list[i]);
    end
  endtask

  task automatic t_flips;
    for (int n = 0; n < 4; n++) begin
      logic [VEC_W-1:0] v = vote_for(5);
      v[pair_pos(5, 6 + n)] = 1'b0;
      run_one(v, "R2 flipped decisions");
    end
  endtask

  task automatic t_dont_care;
    logic [VEC_W-1:0] v = vote_for(11);
    write_code(2, ~v, '0);
    run_one(v, "R3 care-free code");
    check(int'(out_label) == 2 && out_dist == 0, "R3 masked class wins", out_label, 2);
    write_code(2, ~v, {{(VEC_W-1){1'b0}}, 1'b1});
    run_one(v, "R3 one cared bit");
  endtask

  task automatic t_tie;
    logic [VEC_W-1:0] v = vote_for(9);
    write_code(1, v, '1);
    write_code(9, v, '1);
    write_code(2, ~v, '1);
    run_one(v, "R5 tie");
    check(int'(out_label) == 1 && out_dist == 0, "R5 lowest index on tie", out_label, 1);
  endtask

  task automatic t_max_dist;
    logic [VEC_W-1:0] v = vote_for(4);
    for (int c = 0; c < K; c++) write_code(c, ~v, '1);
    run_one(v, "R2 full distance");
    check(int'(out_dist) == VEC_W && out_label == 0, "R2 R5 max distance", out_dist, VEC_W);
    t_load_natural();
  endtask

  task automatic t_stream;
    localparam int N = 8;
    logic [VEC_W-1:0] vs [N];
    for (int i = 0; i < N; i++) vs[i] = vote_for((i * 5) % K);
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int el, ed;
        model(vs[i-2], el, ed);
        check(out_valid == 1'b1, "R7 stream valid", out_valid, 1);
        check(int'(out_label) == el && int'(out_dist) == ed, "R7 stream order", out_label, el);
      end else begin
        check(out_valid == 1'b0, "R6 stream latency", out_valid, 0);
      end
      if (i < N) begin in_valid = 1; in_bits = vs[i]; end
      else in_valid = 0;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R6 R7 stream end", out_valid, 0);
  endtask

  task automatic t_cfg_block;
    logic [VEC_W-1:0] v = vote_for(6);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(13); cfg_value = v; cfg_care = '1;
    in_valid = 1; in_bits = v;
    #1;
    check(in_ready == 1'b0, "R8 ready low during write", in_ready, 0);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    mv[13] = v; mc[13] = '1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 vector during write dropped", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 no late result", out_valid, 0);
    run_one(v, "R8 new code applies");
    check(int'(out_label) == 6, "R8 lower natural code still wins tie", out_label, 6);
    write_code(6, ~v, '1);
    run_one(v, "R8 rewritten code applies");
    check(int'(out_label) == 13, "R8 rewritten class loses", out_label, 13);
  endtask

  initial begin
    for (int c = 0; c < K; c++) begin mv[c] = '0; mc[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_natural();
    t_winners();
    t_flips();
    t_stream();
    t_dont_care();
    t_tie();
    t_load_natural();
    t_cfg_block();
    t_max_dist();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule